// File: doc/BRIEF.md
# Sequenced-Kick Watchdog Timer

This block is a watchdog for a host microcontroller. The host writes an 8-bit control word that holds a two-bit mode select and two kick bits. When the mode select is set to binary 11, the watchdog starts counting system clock cycles toward a timeout. The default timeout is 128 ms, and its length in cycles is derived from the clock frequency parameter. The host keeps the watchdog from expiring only by writing the two kick bits in a strict two-step order before each timeout. A single write, or writes in the wrong order, do not restart the count.

When the count runs out, the block does three things in the same clock edge:
- It sets a sticky overflow flag.
- It raises an active-high interrupt.
- It starts a reset pulse of fixed length.

The host clears the flag by writing 1 to bit 0 of a separate status write port. After an expiry the counter stays idle until the host selects the watchdog mode again.

Top module: `seq_kick_wdt`

## Requirements
- R1: The control register reads back as zero after reset. A control write stores bits [3:0] of the written word: [1:0] is the mode select, bit 2 is the step-one kick bit and bit 3 is the step-two kick bit. Bits [7:4] always read as zero.
- R2: A control write with mode select 11 while the timer is stopped starts it. Expiry occurs at the clock edge TIMEOUT_TICKS cycles after that write, where TIMEOUT_TICKS = CLK_HZ*TIMEOUT_MS/1000.
- R3: A control write with any mode select other than 11 stops the timer, and no expiry follows.
- R4: A write of step-one (bit 2 = 1, bit 3 = 0) followed by a write of step-two (bit 2 = 0, bit 3 = 1), both with mode select 11, restarts the count. The next expiry then falls TIMEOUT_TICKS cycles after the step-two write.
- R5: A step-two write that is not preceded by a step-one write does not restart the count.
- R6: After a step-one write, a following write that is not step-two discards the partial sequence. A later step-two write then does not restart the count.
- R7: Expiry sets the overflow flag and the interrupt output, and both stay set. A status write with bit 0 = 1 clears them. A status write with bit 0 = 0 has no effect.
- R8: The reset pulse goes high in the same cycle the flag is set and stays high for exactly PULSE_CYCLES cycles.
- R9: After an expiry the timer stays stopped and no further expiry occurs. A new control write with mode select 11 starts it again.
- R10: A step-two write that completes a valid sequence on the expiry edge restarts the count, and no expiry occurs on that edge.
- R11: A clear request on the expiry edge loses, so the flag ends the cycle set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_wdata | input | 8 | Control write data |
| cfg_rdata | output | 8 | Current control register contents |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 8 | Status write data; bit 0 = 1 clears the flag |
| wdt_ovf | output | 1 | Sticky overflow flag |
| irq | output | 1 | Active-high interrupt, follows the flag |
| wdt_rst_pulse | output | 1 | Reset pulse issued on expiry |

## Verification
Two pairs of events can fall on the same edge, and each is provoked on purpose.

The first pair is a kick completing and the counter reaching its limit. The bench times the step-two write so that it commits on the exact edge where expiry would occur. It then judges that the flag stays clear on that edge and that the flag rises one full period later.

The second pair is expiry and a host clear. The bench places the status clear on the expiry edge and checks that the flag still reads set afterwards.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [1:0] SEL_WDT = 2'b11;

    typedef struct packed {
        logic       kick_b;
        logic       kick_a;
        logic [1:0] sel;
    } ctrl_t;

    typedef enum logic {
        KS_IDLE  = 1'b0,
        KS_ARMED = 1'b1
    } kick_state_t;

    function automatic logic is_step_one(input ctrl_t c);
        return c.kick_a && !c.kick_b;
    endfunction

    function automatic logic is_step_two(input ctrl_t c);
        return !c.kick_a && c.kick_b;
    endfunction

    function automatic longint unsigned period_ticks(input longint unsigned clk_hz,
                                                     input longint unsigned ms);
        return (clk_hz * ms) / 64'd1000;
    endfunction

endpackage

// File: rtl/wdt_kick_seq.sv
module wdt_kick_seq
    import wdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  wr_valid,
    input  ctrl_t wr_word,
    output logic  restart
);
    kick_state_t state_q;

    assign restart = wr_valid && (state_q == KS_ARMED) && is_step_two(wr_word);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            state_q <= KS_IDLE;
        end else if (wr_valid) begin
            if (is_step_one(wr_word)) begin
                state_q <= KS_ARMED;
            end else begin
                state_q <= KS_IDLE;
            end
        end
    end
endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout #(
    parameter longint unsigned TICKS = 64'd32
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic stop,
    input  logic restart,
    output logic expire,
    output logic running
);
    localparam int CNT_W = $clog2(TICKS + 64'd1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 64'd1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = running && !stop && !restart && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt_q   <= '0;
        end else if (stop) begin
            running <= 1'b0;
            cnt_q   <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt_q   <= '0;
        end else if (running) begin
            if (restart) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                running <= 1'b0;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int unsigned PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic pulse
);
    localparam int PW = $clog2(PULSE_CYCLES + 1);

    logic [PW-1:0] left_q;

    assign pulse = (left_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= PW'(PULSE_CYCLES);
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/seq_kick_wdt.sv
module seq_kick_wdt
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 50_000_000,
    parameter int unsigned TIMEOUT_MS   = 128,
    parameter int unsigned PULSE_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       sts_wr,
    input  logic [7:0] sts_wdata,
    output logic       wdt_ovf,
    output logic       irq,
    output logic       wdt_rst_pulse
);
    localparam longint unsigned TIMEOUT_TICKS = period_ticks(64'(CLK_HZ), 64'(TIMEOUT_MS));

    ctrl_t ctrl_q;
    ctrl_t wr_word;
    logic  mode_sel;
    logic  start;
    logic  stop;
    logic  restart;
    logic  expire;
    logic  running;
    logic  ovf_q;

    assign wr_word  = ctrl_t'(cfg_wdata[3:0]);
    assign mode_sel = (wr_word.sel == SEL_WDT);
    assign start    = cfg_wr && mode_sel && !running;
    assign stop     = cfg_wr && !mode_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (cfg_wr) begin
            ctrl_q <= wr_word;
        end
    end

    wdt_kick_seq u_kick (
        .clk      (clk),
        .rst      (rst),
        .flush    (stop || expire),
        .wr_valid (cfg_wr && mode_sel && running),
        .wr_word  (wr_word),
        .restart  (restart)
    );

    wdt_timeout #(.TICKS(TIMEOUT_TICKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .stop    (stop),
        .restart (restart),
        .expire  (expire),
        .running (running)
    );

    wdt_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .load  (expire),
        .pulse (wdt_rst_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
        end else if (expire) begin
            ovf_q <= 1'b1;
        end else if (sts_wr && sts_wdata[0]) begin
            ovf_q <= 1'b0;
        end
    end

    assign cfg_rdata = {4'b0000, ctrl_q};
    assign wdt_ovf   = ovf_q;
    assign irq       = ovf_q;
endmodule

// File: rtl/wdt_sva.sv
module wdt_sva #(
    parameter int unsigned PULSE_CYCLES = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       cfg_wr,
    input logic [7:0] cfg_wdata,
    input logic       sts_wr,
    input logic [7:0] sts_wdata,
    input logic       wdt_ovf,
    input logic       wdt_rst_pulse,
    input logic       expire,
    input logic       running
);
    localparam int HW = $clog2(PULSE_CYCLES + 2);
    logic [HW-1:0] high_run;

    always_ff @(posedge clk) begin
        if (rst || !wdt_rst_pulse) begin
            high_run <= '0;
        end else begin
            high_run <= high_run + 1'b1;
        end
    end

    p_stop_mode_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_wdata[1:0] != 2'b11) |=> !running);

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (wdt_ovf && !(sts_wr && sts_wdata[0])) |=> wdt_ovf);

    p_ovf_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && sts_wdata[0] && !expire) |=> !wdt_ovf);

    p_expire_effects_r8: assert property (@(posedge clk) disable iff (rst)
        expire |=> (wdt_ovf && wdt_rst_pulse));

    p_pulse_with_flag_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_rst_pulse) |-> wdt_ovf);

    p_pulse_width_r8: assert property (@(posedge clk) disable iff (rst)
        wdt_rst_pulse |-> (high_run < HW'(PULSE_CYCLES)));

    p_stopped_after_expiry_r9: assert property (@(posedge clk) disable iff (rst)
        expire |=> !running);
endmodule

bind seq_kick_wdt wdt_sva #(.PULSE_CYCLES(PULSE_CYCLES)) u_sva (
    .clk           (clk),
    .rst           (rst),
    .cfg_wr        (cfg_wr),
    .cfg_wdata     (cfg_wdata),
    .sts_wr        (sts_wr),
    .sts_wdata     (sts_wdata),
    .wdt_ovf       (wdt_ovf),
    .wdt_rst_pulse (wdt_rst_pulse),
    .expire        (expire),
    .running       (running)
);

// File: tb/seq_kick_wdt_tb.sv
module seq_kick_wdt_tb;
    localparam int unsigned CLK_HZ  = 250;
    localparam int unsigned TMO_MS  = 128;
    localparam int unsigned PULSE   = 4;
    localparam int          T       = 32;   // 250 * 128 / 1000

    localparam int NVEC = 6;
    localparam logic [15:0] VEC [NVEC] = '{
        {8'h05, 8'h05}, {8'hF0, 8'h00}, {8'hAA, 8'h0A},
        {8'h0F, 8'h0F}, {8'h33, 8'h03}, {8'h00, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       sts_wr = 1'b0;
    logic [7:0] sts_wdata = '0;
    logic       wdt_ovf;
    logic       irq;
    logic       wdt_rst_pulse;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    seq_kick_wdt #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TMO_MS), .PULSE_CYCLES(PULSE)) u_dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .wdt_ovf(wdt_ovf), .irq(irq), .wdt_rst_pulse(wdt_rst_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic sts_write(input logic [7:0] d);
        @(negedge clk);
        sts_wr = 1'b1; sts_wdata = d;
        @(negedge clk);
        sts_wr = 1'b0; sts_wdata = '0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        check("R1 reset ctrl", int'(cfg_rdata), 0);
        check("R7 reset flag", int'(wdt_ovf), 0);
        check("R7 reset irq", int'(irq), 0);
        check("R8 reset pulse", int'(wdt_rst_pulse), 0);

        for (int i = 0; i < NVEC; i++) begin
            cfg_write(VEC[i][15:8]);
            check("R1 readback", int'(cfg_rdata), int'(VEC[i][7:0]));
        end

        // R3: start then stop, no expiry
        cfg_write(8'h03);
        wait_n(5);
        cfg_write(8'h00);
        wait_n(T + 5);
        check("R3 stopped no expiry", int'(wdt_ovf), 0);

        // R2/R8: plain timeout
        cfg_write(8'h03);
        wait_n(T - 1);
        check("R2 before timeout", int'(wdt_ovf), 0);
        wait_n(1);
        check("R2 flag at timeout", int'(wdt_ovf), 1);
        check("R7 irq at timeout", int'(irq), 1);
        check("R8 pulse with flag", int'(wdt_rst_pulse), 1);
        wait_n(PULSE - 1);
        check("R8 pulse last cycle", int'(wdt_rst_pulse), 1);
        wait_n(1);
        check("R8 pulse ended", int'(wdt_rst_pulse), 0);
        sts_write(8'h00);
        check("R7 zero write ignored", int'(wdt_ovf), 1);
        sts_write(8'h01);
        check("R7 clear flag", int'(wdt_ovf), 0);
        check("R7 clear irq", int'(irq), 0);
        wait_n(2 * T);
        check("R9 no re-expiry", int'(wdt_ovf), 0);

        // R4: valid kick restarts
        cfg_write(8'h03);
        wait_n(10);
        cfg_write(8'h07);
        cfg_write(8'h0B);
        wait_n(T - 1);
        check("R4 no expiry before restarted period", int'(wdt_ovf), 0);
        wait_n(1);
        check("R4 expiry after restarted period", int'(wdt_ovf), 1);
        sts_write(8'h01);

        // R5: lone step two
        cfg_write(8'h03);
        wait_n(10);
        cfg_write(8'h0B);
        wait_n(T - 12 - 1);
        check("R5 before original timeout", int'(wdt_ovf), 0);
        wait_n(1);
        check("R5 lone step-two ignored", int'(wdt_ovf), 1);
        sts_write(8'h01);

        // R6: broken sequence
        cfg_write(8'h03);
        cfg_write(8'h07);
        cfg_write(8'h03);
        cfg_write(8'h0B);
        wait_n(T - 6 - 1);
        check("R6 before original timeout", int'(wdt_ovf), 0);
        wait_n(1);
        check("R6 broken sequence ignored", int'(wdt_ovf), 1);
        sts_write(8'h01);

        // R10: kick completes on expiry edge
        cfg_write(8'h03);
        cfg_write(8'h07);
        wait_n(T - 4);
        cfg_write(8'h0B);
        check("R10 kick wins on expiry edge", int'(wdt_ovf), 0);
        wait_n(T - 1);
        check("R10 before new period end", int'(wdt_ovf), 0);
        wait_n(1);
        check("R10 expiry after new period", int'(wdt_ovf), 1);

        // R9 + R11: restart after expiry, clear collides with expiry
        cfg_write(8'h03);
        wait_n(T - 2);
        sts_write(8'h01);
        check("R11 set beats clear", int'(wdt_ovf), 1);
        check("R9 restarted after expiry", int'(wdt_rst_pulse), 1);
        sts_write(8'h01);
        check("R7 clear after collision", int'(wdt_ovf), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule